// File: doc/BRIEF.md
# Metering accumulation interval sequencer

This block paces the compute engine of an energy-metering datapath. Each sample strobe delivers one channel sample, and the block steps a channel selector through four inputs in a fixed order: current A, voltage A, current B, voltage B. When the last channel of a multiplexer cycle has been taken, the block raises a processing-busy level for a fixed number of clocks while the engine works on that cycle's samples.

Mux cycles are counted against two programmable counts: samples per pre-sum and pre-sums per interval. When the number of mux cycles reaches the product of the two, the accumulation interval closes. After the processing-busy period of that last cycle, a transfer-busy level marks the time the completed sums are written to output memory. Its length is programmable.

The host processor is told of the end of each busy period. It gets a one-cycle interrupt pulse on each falling edge and a sticky flag that it clears by writing a 1. Both counts are captured in a one-cycle load step at the start of every interval, so host writes made mid-interval apply to the next interval.

Top module: `accum_seq_top`

States: LOAD (capture configuration) → GATHER (accept strobes) → PROC (processing busy) → back to GATHER, or → XFER (transfer busy) when the interval has ended → LOAD.

## Requirements
- R1: `chan_sel` encodes the channel as 0 = current A, 1 = voltage A, 2 = current B, 3 = voltage B. It advances by one on each accepted strobe and returns to 0 after channel 3.
- R2: The accepted strobe on channel 3 completes a mux cycle. `proc_busy` is high from the next clock for exactly PROC_CYCLES cycles, once per mux cycle.
- R3: `xfer_busy` rises only in the cycle right after `proc_busy` falls for the last mux cycle of an interval. It is never high together with `proc_busy`.
- R4: An accumulation interval lasts max(samples-per-pre-sum,1) × max(pre-sums,1) mux cycles.
- R5: `xfer_busy` stays high for max(`cfg_xfer_len`,1) cycles. The length is sampled when the transfer starts.
- R6: `proc_irq` and `xfer_irq` pulse for exactly one cycle, in the first cycle that the matching busy level reads low after being high.
- R7: `proc_flag` and `xfer_flag` are set by their interrupt pulse and hold until `flag_clr` bit 0 (processing) or bit 1 (transfer) is written as 1. A set and a clear in the same cycle leave the flag set.
- R8: During reset `chan_sel` is 0 and every busy, interrupt and flag output is 0.
- R9: Both counts are sampled in the LOAD cycle after reset and after every transfer. Changes during an interval take effect at the next interval.
- R10: A zero in either count, or in `cfg_xfer_len`, acts as 1.
- R11: Strobes are ignored in PROC, in XFER and in the LOAD cycle, and `chan_sel` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One channel sample delivered |
| cfg_pre_samps | input | CNT_W | Mux cycles per pre-sum |
| cfg_sum_cycles | input | CNT_W | Pre-sums per interval |
| cfg_xfer_len | input | XLEN_W | Transfer-busy length in clocks |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 processing flag, bit 1 transfer flag |
| chan_sel | output | CH_W | Channel to sample next |
| proc_busy | output | 1 | Processing busy level |
| xfer_busy | output | 1 | Transfer busy level |
| proc_irq | output | 1 | Pulse on processing-busy fall |
| xfer_irq | output | 1 | Pulse on transfer-busy fall |
| proc_flag | output | 1 | Sticky processing interrupt flag |
| xfer_flag | output | 1 | Sticky transfer interrupt flag |

## Verification
The hardest situation to reach is a host write of the counts in the middle of an interval. The write has to land on a particular mux cycle, and its effect shows only one whole interval later. The stimulus first sets up a two-cycle interval and lowers the count after its first mux cycle. It then checks that the transfer still comes at the second cycle, and that the following interval is one cycle long. It also sends strobes through whole busy periods and through the single LOAD cycle, and checks that the channel selector does not move.

// File: rtl/accum_seq_pkg.sv
package accum_seq_pkg;
    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_GATHER = 2'd1,
        ST_PROC   = 2'd2,
        ST_XFER   = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        CH_CUR_A  = 2'd0,
        CH_VOLT_A = 2'd1,
        CH_CUR_B  = 2'd2,
        CH_VOLT_B = 2'd3
    } chan_t;

    localparam int IRQ_PROC = 0;
    localparam int IRQ_XFER = 1;
    localparam int IRQ_NUM  = 2;
endpackage

// File: rtl/acc_chan_step.sv
module acc_chan_step #(
    parameter int CH_NUM = 4,
    parameter int CH_W   = $clog2(CH_NUM)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [CH_W-1:0] chan,
    output logic            wrap
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(CH_NUM - 1);

    assign wrap = adv && (chan == LAST_CH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan <= '0;
        end else if (adv) begin
            chan <= wrap ? '0 : chan + 1'b1;
        end
    end
endmodule

// File: rtl/acc_ivl_count.sv
module acc_ivl_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cfg_pre,
    input  logic [CNT_W-1:0] cfg_sum,
    input  logic             adv,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] pre_lim, sum_lim;
    logic [CNT_W-1:0] samp_cnt, sum_cnt;
    logic             samp_wrap, sum_wrap;

    assign samp_wrap = (samp_cnt == pre_lim - ONE);
    assign sum_wrap  = (sum_cnt == sum_lim - ONE);
    assign last      = samp_wrap && sum_wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_lim  <= ONE;
            sum_lim  <= ONE;
            samp_cnt <= '0;
            sum_cnt  <= '0;
        end else if (load) begin
            pre_lim  <= (cfg_pre == '0) ? ONE : cfg_pre;
            sum_lim  <= (cfg_sum == '0) ? ONE : cfg_sum;
            samp_cnt <= '0;
            sum_cnt  <= '0;
        end else if (adv) begin
            if (samp_wrap) begin
                samp_cnt <= '0;
                sum_cnt  <= sum_wrap ? '0 : sum_cnt + ONE;
            end else begin
                samp_cnt <= samp_cnt + ONE;
            end
        end
    end
endmodule

// File: rtl/acc_irq_edge.sv
module acc_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic clr,
    output logic irq,
    output logic flag
);
    logic busy_d1;

    assign irq = busy_d1 && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_d1 <= 1'b0;
            flag    <= 1'b0;
        end else begin
            busy_d1 <= busy;
            if (irq) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/accum_seq_top.sv
module accum_seq_top
    import accum_seq_pkg::*;
#(
    parameter int CH_NUM      = 4,
    parameter int CH_W        = $clog2(CH_NUM),
    parameter int CNT_W       = 8,
    parameter int XLEN_W      = 8,
    parameter int PROC_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [CNT_W-1:0]  cfg_pre_samps,
    input  logic [CNT_W-1:0]  cfg_sum_cycles,
    input  logic [XLEN_W-1:0] cfg_xfer_len,
    input  logic [1:0]        flag_clr,
    output logic [CH_W-1:0]   chan_sel,
    output logic              proc_busy,
    output logic              xfer_busy,
    output logic              proc_irq,
    output logic              xfer_irq,
    output logic              proc_flag,
    output logic              xfer_flag
);
    localparam int PC_W = $clog2(PROC_CYCLES + 1);
    localparam logic [PC_W-1:0]   PROC_LAST = PC_W'(PROC_CYCLES - 1);
    localparam logic [XLEN_W-1:0] XONE      = XLEN_W'(1);

    seq_state_t        state, nxt;
    logic [PC_W-1:0]   proc_cnt;
    logic [XLEN_W-1:0] xfer_cnt, xfer_lim;
    logic              ivl_done;
    logic              stb_ok, mux_done, ivl_last;
    logic [IRQ_NUM-1:0] busy_vec, irq_vec, flag_vec;

    assign stb_ok = sample_stb && (state == ST_GATHER);

    acc_chan_step #(.CH_NUM(CH_NUM), .CH_W(CH_W)) chan_i (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (stb_ok),
        .chan (chan_sel),
        .wrap (mux_done)
    );

    acc_ivl_count #(.CNT_W(CNT_W)) ivl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state == ST_LOAD),
        .cfg_pre(cfg_pre_samps),
        .cfg_sum(cfg_sum_cycles),
        .adv    (mux_done),
        .last   (ivl_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOAD:   nxt = ST_GATHER;
            ST_GATHER: if (mux_done) nxt = ST_PROC;
            ST_PROC:   if (proc_cnt == PROC_LAST) nxt = ivl_done ? ST_XFER : ST_GATHER;
            ST_XFER:   if (xfer_cnt == xfer_lim - XONE) nxt = ST_LOAD;
            default:   nxt = ST_LOAD;
        endcase
    end

    // Dwell timers and interval-end marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proc_cnt <= '0;
            xfer_cnt <= '0;
            xfer_lim <= XONE;
            ivl_done <= 1'b0;
        end else begin
            if (state != nxt) begin
                proc_cnt <= '0;
                xfer_cnt <= '0;
            end else if (state == ST_PROC) begin
                proc_cnt <= proc_cnt + 1'b1;
            end else if (state == ST_XFER) begin
                xfer_cnt <= xfer_cnt + XONE;
            end
            if (state == ST_PROC && nxt == ST_XFER) begin
                xfer_lim <= (cfg_xfer_len == '0) ? XONE : cfg_xfer_len;
                ivl_done <= 1'b0;
            end else if (mux_done && ivl_last) begin
                ivl_done <= 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        proc_busy = 1'b0;
        xfer_busy = 1'b0;
        unique case (state)
            ST_LOAD:   ;
            ST_GATHER: ;
            ST_PROC:   proc_busy = 1'b1;
            ST_XFER:   xfer_busy = 1'b1;
            default:   ;
        endcase
    end

    assign busy_vec[IRQ_PROC] = proc_busy;
    assign busy_vec[IRQ_XFER] = xfer_busy;

    for (genvar g = 0; g < IRQ_NUM; g++) begin : g_irq
        acc_irq_edge irq_i (
            .clk  (clk),
            .rst_n(rst_n),
            .busy (busy_vec[g]),
            .clr  (flag_clr[g]),
            .irq  (irq_vec[g]),
            .flag (flag_vec[g])
        );
    end

    assign proc_irq  = irq_vec[IRQ_PROC];
    assign xfer_irq  = irq_vec[IRQ_XFER];
    assign proc_flag = flag_vec[IRQ_PROC];
    assign xfer_flag = flag_vec[IRQ_XFER];
endmodule

// File: rtl/accum_seq_chk.sv
module accum_seq_chk #(
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CH_W-1:0] chan_sel,
    input logic            proc_busy,
    input logic            xfer_busy,
    input logic            proc_irq,
    input logic            xfer_irq,
    input logic            proc_flag,
    input logic            xfer_flag
);
    // R1
    chan_wrapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proc_busy |-> chan_sel == '0);

    // R3
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(proc_busy && xfer_busy));

    // R3
    xfer_after_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> $past(proc_busy));

    // R6
    proc_irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proc_irq |-> (!proc_busy && $past(proc_busy)));

    // R6
    xfer_irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_busy) |-> xfer_irq);

    // R7
    xfer_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_irq |=> xfer_flag);

    // R7
    proc_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proc_irq |=> proc_flag);

    // R11
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_busy || xfer_busy) |=> $stable(chan_sel));
endmodule

bind accum_seq_top accum_seq_chk #(.CH_W(CH_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_sel (chan_sel),
    .proc_busy(proc_busy),
    .xfer_busy(xfer_busy),
    .proc_irq (proc_irq),
    .xfer_irq (xfer_irq),
    .proc_flag(proc_flag),
    .xfer_flag(xfer_flag)
);

// File: tb/accum_seq_top_tb_top.sv
`timescale 1ns/1ps
module accum_seq_top_tb_top;
    localparam int PROC_N = 4;
    localparam int NVEC   = 5;
    // {pre, sum, xlen}
    localparam logic [23:0] VECS [NVEC] = '{
        24'h01_01_03, 24'h02_03_02, 24'h03_02_05, 24'h00_00_00, 24'h04_01_01
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_stb = 1'b0;
    logic [7:0] cfg_pre_samps = 8'd1, cfg_sum_cycles = 8'd1, cfg_xfer_len = 8'd1;
    logic [1:0] flag_clr = 2'b00;
    logic [1:0] chan_sel;
    logic       proc_busy, xfer_busy, proc_irq, xfer_irq, proc_flag, xfer_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    accum_seq_top #(.PROC_CYCLES(PROC_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .cfg_pre_samps(cfg_pre_samps), .cfg_sum_cycles(cfg_sum_cycles),
        .cfg_xfer_len(cfg_xfer_len), .flag_clr(flag_clr),
        .chan_sel(chan_sel), .proc_busy(proc_busy), .xfer_busy(xfer_busy),
        .proc_irq(proc_irq), .xfer_irq(xfer_irq),
        .proc_flag(proc_flag), .xfer_flag(xfer_flag)
    );

    function automatic int max1(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int pre, input int sum, input int xl);
        cfg_pre_samps = 8'(pre);
        cfg_sum_cycles = 8'(sum);
        cfg_xfer_len = 8'(xl);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(chan_sel == 2'd0, "R8 chan_sel", chan_sel, 0);
        check({proc_busy, xfer_busy, proc_irq, xfer_irq, proc_flag, xfer_flag} == 6'b0,
              "R8 outputs", {proc_busy, xfer_busy, proc_irq, xfer_irq, proc_flag, xfer_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One mux cycle: four strobes, then the busy periods that follow.
    task automatic run_mux(input bit exp_xfer, input int exp_xlen,
                           input bit stb_busy, input bit stb_load);
        int n;
        int m;
        for (int c = 0; c < 4; c++) begin
            check(chan_sel == 2'(c), "R1 channel order", chan_sel, c);
            sample_stb = 1'b1;
            @(negedge clk);
            sample_stb = 1'b0;
        end
        n = 0;
        while (proc_busy && n < 100) begin
            n++;
            sample_stb = stb_busy;
            @(negedge clk);
        end
        sample_stb = 1'b0;
        check(n == PROC_N, "R2 proc_busy width", n, PROC_N);
        check(proc_irq == 1'b1, "R6 proc_irq on fall", proc_irq, 1);
        check(xfer_busy == exp_xfer, "R4 interval end", xfer_busy, exp_xfer);
        if (exp_xfer) begin
            check(proc_busy == 1'b0, "R3 no overlap", proc_busy, 0);
            m = 0;
            while (xfer_busy && m < 300) begin
                m++;
                sample_stb = stb_busy;
                @(negedge clk);
            end
            sample_stb = 1'b0;
            check(m == exp_xlen, "R5 xfer_busy width", m, exp_xlen);
            check(xfer_irq == 1'b1, "R6 xfer_irq on fall", xfer_irq, 1);
            sample_stb = stb_load;
            @(negedge clk);
            sample_stb = 1'b0;
        end else begin
            check(xfer_irq == 1'b0, "R3 no transfer mid-interval", xfer_irq, 0);
        end
        @(negedge clk);
        check(proc_irq == 1'b0, "R6 one-cycle pulse", proc_irq, 0);
        check(chan_sel == 2'd0, "R11 strobes ignored while busy", chan_sel, 0);
    endtask

    initial begin
        // Table-driven intervals
        for (int v = 0; v < NVEC; v++) begin
            int pre;
            int sum;
            int xl;
            int total;
            pre = int'(VECS[v][23:16]);
            sum = int'(VECS[v][15:8]);
            xl  = int'(VECS[v][7:0]);
            do_reset(pre, sum, xl);
            total = max1(pre) * max1(sum);
            for (int k = 1; k <= total; k++) begin
                run_mux(k == total, max1(xl), 1'b0, 1'b0);
            end
            check(proc_flag && xfer_flag, "R7 flags set", {proc_flag, xfer_flag}, 3);
            flag_clr = 2'b01;
            @(negedge clk);
            flag_clr = 2'b00;
            check(!proc_flag && xfer_flag, "R7 clear bit 0 only", {proc_flag, xfer_flag}, 1);
            flag_clr = 2'b10;
            @(negedge clk);
            flag_clr = 2'b00;
            check(!proc_flag && !xfer_flag, "R7 clear bit 1", {proc_flag, xfer_flag}, 0);
        end

        // R10: zero counts and zero transfer length behave as 1
        do_reset(0, 0, 0);
        run_mux(1'b1, 1, 1'b0, 1'b0);
        run_mux(1'b1, 1, 1'b0, 1'b0);

        // R9: mid-interval configuration changes wait for the next interval
        do_reset(2, 1, 2);
        run_mux(1'b0, 2, 1'b0, 1'b0);
        cfg_pre_samps = 8'd1;
        run_mux(1'b1, 2, 1'b0, 1'b0);
        run_mux(1'b1, 2, 1'b0, 1'b0);
        cfg_pre_samps = 8'd3;
        cfg_xfer_len = 8'd4;
        run_mux(1'b1, 4, 1'b0, 1'b0);
        run_mux(1'b0, 4, 1'b0, 1'b0);
        run_mux(1'b0, 4, 1'b0, 1'b0);
        run_mux(1'b1, 4, 1'b0, 1'b0);

        // R11: strobes held high through busy periods and the load cycle
        do_reset(1, 2, 3);
        run_mux(1'b0, 3, 1'b1, 1'b1);
        run_mux(1'b1, 3, 1'b1, 1'b1);
        run_mux(1'b0, 3, 1'b1, 1'b1);

        // R7: set wins over a same-cycle clear
        do_reset(1, 1, 1);
        for (int c = 0; c < 4; c++) begin
            sample_stb = 1'b1;
            @(negedge clk);
            sample_stb = 1'b0;
        end
        while (proc_busy) @(negedge clk);
        flag_clr = 2'b01;
        @(negedge clk);
        flag_clr = 2'b00;
        check(proc_flag == 1'b1, "R7 set beats clear", proc_flag, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule